// File: doc/BRIEF.md
# Self-Invalidating Release-Consistency Cache Controller

This block is the controller of a small private data cache that keeps memory consistent under release consistency, without coherence traffic. It holds no sharer lists and receives no invalidations from other agents. Ordinary loads and stores work only against the local direct-mapped array. The ordering points are the two synchronising operations. A release pushes every dirty shared line, and the release datum itself, down to the shared lower level. An acquire always reads the lower level and then drops every shared line from the local array, so later loads fetch fresh copies.

Each line carries a valid bit, a dirty bit and a private bit. The private bit is supplied with the request that fills the line. Private lines take no part in the release flush or the acquire invalidation. They still leave the array through ordinary eviction, which writes them back when they are dirty.

On the core side, a request is held steady until `stall` is seen low, and is taken on that clock edge. While `stall` is low, `rsp_valid` marks the cycle in which the response data is valid. On the memory side there is one outstanding request at a time. A write completes on its ready/valid handshake. A read completes when `mem_rsp_valid` returns one line.

Top module: `rc_cache_ctrl`

## Requirements
- R1: After reset, with no request presented, `stall` and `mem_req_valid` are low, and the first load to any address fetches from the lower level.
- R2: A load (op code 0) to a line held in the array returns the cached data with `stall` low in the same cycle and makes no memory request. A load that misses reads the line from the lower level and returns that value.
- R3: A store (op code 1) writes only the local array and issues no write to the lower level. A later load of the same address returns the stored value.
- R4: A load or store miss whose line slot holds a dirty line first writes that line back to its own address, then refills the slot from the lower level.
- R5: A release (op code 3) is acknowledged only after every dirty non-private line and the release datum have been written to the lower level. The flush clears the dirty bits, so a second release with no stores in between writes only its own datum.
- R6: Lines filled with the private bit set are neither written back by a release nor invalidated by an acquire. Their local value survives both.
- R7: An acquire (op code 2) always reads the lower level, even when the address is cached, and returns the value read from memory.
- R8: After an acquire is acknowledged, no non-private line remains valid, so the next load of such an address fetches from the lower level.
- R9: `stall` stays high for the whole walk over the line indices. While the memory port is held not-ready, the walk does not advance and the request fields on the memory port stay stable.
- R10: A dirty non-private line found by the acquire walk is written back before it is invalidated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_op | input | 2 | 0 load, 1 store, 2 acquire load, 3 release store |
| req_addr | input | AW | Word address; low bits select the line |
| req_wdata | input | DW | Store or release data |
| req_priv | input | 1 | Marks the line filled by this request as private |
| stall | output | 1 | Request not yet taken; hold inputs |
| rsp_valid | output | 1 | Request taken this cycle; `rsp_rdata` valid for loads |
| rsp_rdata | output | DW | Load or acquire data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Line address at the lower level |
| mem_req_wdata | output | DW | Write-back data |
| mem_req_ready | input | 1 | Lower level accepts the request |
| mem_rsp_valid | input | 1 | Read data returning |
| mem_rsp_rdata | input | DW | Read data |

## Verification
The two functions that can land on the same cycle are the write-back of a dirty line found by a walk and the step of the walk index to the next line. When memory is ready, the dirty bit is cleared and the index moves in one cycle. This is provoked by holding `mem_req_ready` low for many cycles while a release walks over several dirty lines, then letting it go. The run is judged by checking three things: `stall` stayed high for longer than the hold, exactly the expected number of writes reached memory, and each dirty line reached its own address with its own data.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_ACQ   = 2'd2,
      OP_REL   = 2'd3
   } op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_EVICT,
      ST_FILL_REQ,
      ST_FILL_WAIT,
      ST_ACQ_REQ,
      ST_ACQ_WAIT,
      ST_ACQ_WALK,
      ST_ACQ_DONE,
      ST_REL_WALK,
      ST_REL_WR,
      ST_REL_DONE
   } state_e;

endpackage

// File: rtl/rcc_line_store.sv
module rcc_line_store #(
   parameter int LINES      = 16,
   parameter int TAG_W      = 4,
   parameter int DW         = 32,
   parameter bit CLEAR_DATA = 1'b1,
   localparam int IDX_W     = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             we,
   input  logic             w_valid,
   input  logic             w_dirty,
   input  logic             w_priv,
   input  logic [TAG_W-1:0] w_tag,
   input  logic [DW-1:0]    w_data,
   output logic             r_valid,
   output logic             r_dirty,
   output logic             r_priv,
   output logic [TAG_W-1:0] r_tag,
   output logic [DW-1:0]    r_data
);

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [LINES-1:0] priv_q;
   logic [TAG_W-1:0] tag_q  [LINES];
   logic [DW-1:0]    data_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         priv_q  <= '0;
         for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
      end else if (we) begin
         valid_q[idx] <= w_valid;
         dirty_q[idx] <= w_dirty;
         priv_q[idx]  <= w_priv;
         tag_q[idx]   <= w_tag;
      end
   end

   generate
      if (CLEAR_DATA) begin : g_data_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < LINES; i++) data_q[i] <= '0;
            end else if (we) begin
               data_q[idx] <= w_data;
            end
         end
      end else begin : g_data_norst
         always_ff @(posedge clk) begin
            if (we) data_q[idx] <= w_data;
         end
      end
   endgenerate

   assign r_valid = valid_q[idx];
   assign r_dirty = dirty_q[idx];
   assign r_priv  = priv_q[idx];
   assign r_tag   = tag_q[idx];
   assign r_data  = data_q[idx];

endmodule

// File: rtl/rcc_walk_ctr.sv
module rcc_walk_ctr #(
   parameter int LINES  = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] idx,
   output logic             last
);

   logic [IDX_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (adv) cnt_q <= cnt_q + 1'b1;
   end

   assign idx  = cnt_q;
   assign last = (cnt_q == IDX_W'(LINES - 1));

endmodule

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
   import rcc_pkg::*;
#(
   parameter int AW     = 8,
   parameter int DW     = 32,
   parameter int LINES  = 16,
   localparam int IDX_W = $clog2(LINES),
   localparam int TAG_W = AW - IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_op,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_wdata,
   input  logic             req_priv,
   output logic             stall,
   output logic             rsp_valid,
   output logic [DW-1:0]    rsp_rdata,
   output logic             mem_req_valid,
   output logic             mem_req_we,
   output logic [AW-1:0]    mem_req_addr,
   output logic [DW-1:0]    mem_req_wdata,
   input  logic             mem_req_ready,
   input  logic             mem_rsp_valid,
   input  logic [DW-1:0]    mem_rsp_rdata,
   output logic [IDX_W-1:0] line_idx,
   output logic             line_we,
   output logic             w_valid,
   output logic             w_dirty,
   output logic             w_priv,
   output logic [TAG_W-1:0] w_tag,
   output logic [DW-1:0]    w_data,
   input  logic             r_valid,
   input  logic             r_dirty,
   input  logic             r_priv,
   input  logic [TAG_W-1:0] r_tag,
   input  logic [DW-1:0]    r_data,
   output logic             walk_adv,
   input  logic [IDX_W-1:0] walk_idx,
   input  logic             walk_last
);

   state_e state_q, state_d;
   logic [DW-1:0] acq_q;
   logic          acq_ld;

   op_e              op;
   logic [IDX_W-1:0] req_idx;
   logic [TAG_W-1:0] req_tag;
   logic             hit;
   logic             walking;

   assign op      = op_e'(req_op);
   assign req_idx = req_addr[IDX_W-1:0];
   assign req_tag = req_addr[AW-1:IDX_W];
   assign walking = (state_q == ST_ACQ_WALK) || (state_q == ST_REL_WALK);
   assign line_idx = walking ? walk_idx : req_idx;
   assign hit     = r_valid && (r_tag == req_tag);

   always_comb begin
      state_d       = state_q;
      stall         = 1'b1;
      rsp_valid     = 1'b0;
      rsp_rdata     = r_data;
      mem_req_valid = 1'b0;
      mem_req_we    = 1'b0;
      mem_req_addr  = req_addr;
      mem_req_wdata = req_wdata;
      line_we       = 1'b0;
      w_valid       = r_valid;
      w_dirty       = r_dirty;
      w_priv        = r_priv;
      w_tag         = r_tag;
      w_data        = r_data;
      walk_adv      = 1'b0;
      acq_ld        = 1'b0;

      unique case (state_q)
         ST_IDLE: begin
            if (!req_valid) begin
               stall = 1'b0;
            end else begin
               unique case (op)
                  OP_LOAD, OP_STORE: begin
                     if (hit) begin
                        stall     = 1'b0;
                        rsp_valid = 1'b1;
                        if (op == OP_STORE) begin
                           line_we = 1'b1;
                           w_dirty = 1'b1;
                           w_data  = req_wdata;
                        end
                     end else if (r_valid && r_dirty) begin
                        state_d = ST_EVICT;
                     end else begin
                        state_d = ST_FILL_REQ;
                     end
                  end
                  OP_ACQ:  state_d = ST_ACQ_REQ;
                  OP_REL:  state_d = ST_REL_WALK;
                  default: state_d = ST_IDLE;
               endcase
            end
         end

         ST_EVICT: begin
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b1;
            mem_req_addr  = {r_tag, req_idx};
            mem_req_wdata = r_data;
            if (mem_req_ready) begin
               line_we = 1'b1;
               w_dirty = 1'b0;
               state_d = ST_FILL_REQ;
            end
         end

         ST_FILL_REQ: begin
            mem_req_valid = 1'b1;
            if (mem_req_ready) state_d = ST_FILL_WAIT;
         end

         ST_FILL_WAIT: begin
            if (mem_rsp_valid) begin
               line_we = 1'b1;
               w_valid = 1'b1;
               w_dirty = 1'b0;
               w_priv  = req_priv;
               w_tag   = req_tag;
               w_data  = mem_rsp_rdata;
               state_d = ST_IDLE;
            end
         end

         ST_ACQ_REQ: begin
            mem_req_valid = 1'b1;
            if (mem_req_ready) state_d = ST_ACQ_WAIT;
         end

         ST_ACQ_WAIT: begin
            if (mem_rsp_valid) begin
               acq_ld  = 1'b1;
               state_d = ST_ACQ_WALK;
            end
         end

         ST_ACQ_WALK: begin
            if (r_valid && !r_priv && r_dirty) begin
               mem_req_valid = 1'b1;
               mem_req_we    = 1'b1;
               mem_req_addr  = {r_tag, walk_idx};
               mem_req_wdata = r_data;
               walk_adv      = mem_req_ready;
            end else begin
               walk_adv = 1'b1;
            end
            if (walk_adv && r_valid && !r_priv) begin
               line_we = 1'b1;
               w_valid = 1'b0;
               w_dirty = 1'b0;
            end
            if (walk_adv && walk_last) state_d = ST_ACQ_DONE;
         end

         ST_ACQ_DONE: begin
            stall     = 1'b0;
            rsp_valid = 1'b1;
            rsp_rdata = acq_q;
            state_d   = ST_IDLE;
         end

         ST_REL_WALK: begin
            if (r_valid && !r_priv && r_dirty) begin
               mem_req_valid = 1'b1;
               mem_req_we    = 1'b1;
               mem_req_addr  = {r_tag, walk_idx};
               mem_req_wdata = r_data;
               walk_adv      = mem_req_ready;
               if (mem_req_ready) begin
                  line_we = 1'b1;
                  w_dirty = 1'b0;
               end
            end else begin
               walk_adv = 1'b1;
            end
            if (walk_adv && walk_last) state_d = ST_REL_WR;
         end

         ST_REL_WR: begin
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b1;
            if (mem_req_ready) begin
               state_d = ST_REL_DONE;
               if (hit) begin
                  line_we = 1'b1;
                  w_dirty = 1'b0;
                  w_data  = req_wdata;
               end else if (!(r_valid && r_dirty)) begin
                  line_we = 1'b1;
                  w_valid = 1'b1;
                  w_dirty = 1'b0;
                  w_priv  = 1'b0;
                  w_tag   = req_tag;
                  w_data  = req_wdata;
               end
            end
         end

         ST_REL_DONE: begin
            stall     = 1'b0;
            rsp_valid = 1'b1;
            state_d   = ST_IDLE;
         end

         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         acq_q   <= '0;
      end else begin
         state_q <= state_d;
         if (acq_ld) acq_q <= mem_rsp_rdata;
      end
   end

endmodule

// File: rtl/rc_cache_ctrl.sv
module rc_cache_ctrl #(
   parameter int AW         = 8,
   parameter int DW         = 32,
   parameter int LINES      = 16,
   parameter bit CLEAR_DATA = 1'b1,
   localparam int IDX_W     = $clog2(LINES),
   localparam int TAG_W     = AW - IDX_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          req_priv,
   output logic          stall,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          mem_req_valid,
   output logic          mem_req_we,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_wdata,
   input  logic          mem_req_ready,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_rdata
);

   generate
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two of at least 2");
      end
      if (AW <= IDX_W) begin : g_bad_aw
         $error("AW must exceed the index width");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   logic [IDX_W-1:0] line_idx;
   logic             line_we;
   logic             w_valid, w_dirty, w_priv;
   logic [TAG_W-1:0] w_tag;
   logic [DW-1:0]    w_data;
   logic             r_valid, r_dirty, r_priv;
   logic [TAG_W-1:0] r_tag;
   logic [DW-1:0]    r_data;
   logic             walk_adv;
   logic [IDX_W-1:0] walk_idx;
   logic             walk_last;

   rcc_line_store #(
      .LINES(LINES), .TAG_W(TAG_W), .DW(DW), .CLEAR_DATA(CLEAR_DATA)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .idx(line_idx), .we(line_we),
      .w_valid(w_valid), .w_dirty(w_dirty), .w_priv(w_priv),
      .w_tag(w_tag), .w_data(w_data),
      .r_valid(r_valid), .r_dirty(r_dirty), .r_priv(r_priv),
      .r_tag(r_tag), .r_data(r_data)
   );

   rcc_walk_ctr #(.LINES(LINES)) u_walk (
      .clk(clk), .rst_n(rst_n), .adv(walk_adv),
      .idx(walk_idx), .last(walk_last)
   );

   rcc_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_priv(req_priv),
      .stall(stall), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata),
      .line_idx(line_idx), .line_we(line_we),
      .w_valid(w_valid), .w_dirty(w_dirty), .w_priv(w_priv),
      .w_tag(w_tag), .w_data(w_data),
      .r_valid(r_valid), .r_dirty(r_dirty), .r_priv(r_priv),
      .r_tag(r_tag), .r_data(r_data),
      .walk_adv(walk_adv), .walk_idx(walk_idx), .walk_last(walk_last)
   );

endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [1:0]    req_op,
   input logic [AW-1:0] req_addr,
   input logic          stall,
   input logic          rsp_valid,
   input logic          mem_req_valid,
   input logic          mem_req_we,
   input logic [AW-1:0] mem_req_addr,
   input logic [DW-1:0] mem_req_wdata,
   input logic          mem_req_ready
);

   logic taken;
   logic acq_rd_seen;
   logic rel_wr_seen;

   assign taken = req_valid && !stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acq_rd_seen <= 1'b0;
         rel_wr_seen <= 1'b0;
      end else begin
         if (taken) acq_rd_seen <= 1'b0;
         else if (req_valid && req_op == 2'd2 && mem_req_valid && mem_req_ready && !mem_req_we)
            acq_rd_seen <= 1'b1;
         if (taken) rel_wr_seen <= 1'b0;
         else if (req_valid && req_op == 2'd3 && mem_req_valid && mem_req_ready && mem_req_we
                  && mem_req_addr == req_addr)
            rel_wr_seen <= 1'b1;
      end
   end

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr) && $stable(mem_req_wdata)); // R9

   AST_STORE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      taken && req_op == 2'd1 |-> !mem_req_valid); // R3

   AST_ACQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      taken && req_op == 2'd2 |-> acq_rd_seen); // R7

   AST_REL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      taken && req_op == 2'd3 |-> rel_wr_seen); // R5

   AST_RSP_ONLY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_valid && !stall); // R2

endmodule

bind rc_cache_ctrl rcc_checker #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .req_addr(req_addr), .stall(stall), .rsp_valid(rsp_valid),
   .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
   .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
   .mem_req_ready(mem_req_ready)
);

// File: tb/sim_rc_cache_ctrl.sv
`timescale 1ns/1ps
module sim_rc_cache_ctrl;

   localparam int AW = 8;
   localparam int DW = 32;
   localparam logic [1:0] LD = 2'd0, ST = 2'd1, AQ = 2'd2, RL = 2'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_priv = 1'b0;
   logic          stall, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          mem_req_valid, mem_req_we;
   logic [AW-1:0] mem_req_addr;
   logic [DW-1:0] mem_req_wdata;
   logic          mem_req_ready;
   logic          mem_rsp_valid = 1'b0;
   logic [DW-1:0] mem_rsp_rdata = '0;
   logic          mem_hold = 1'b0;

   logic [DW-1:0] mem [256];
   int wr_cnt = 0;
   int rd_cnt = 0;
   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rc_cache_ctrl #(.AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_priv(req_priv),
      .stall(stall), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata)
   );

   assign mem_req_ready = !mem_hold;

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_we) begin
            mem[mem_req_addr] <= mem_req_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rsp_rdata <= mem[mem_req_addr];
            mem_rsp_valid <= 1'b1;
            rd_cnt <= rd_cnt + 1;
         end
      end
   end

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] v);
      @(negedge clk);
      mem[a] = v;
   endtask

   task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic p, output logic [DW-1:0] rd, output int cyc);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_priv = p;
      #1;
      cyc = 0;
      while (stall && cyc < 5000) begin
         @(negedge clk); #1;
         cyc++;
      end
      rd = rsp_rdata;
      chk("R2 rsp_valid on take", {31'b0, rsp_valid}, 32'd1);
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      chk("R1 stall after reset", {31'b0, stall}, 32'd0);
      chk("R1 mem idle after reset", {31'b0, mem_req_valid}, 32'd0);
   endtask

   task automatic t_load();
      logic [DW-1:0] rd; int cyc; int r0, w0;
      poke(8'h05, 32'hA1);
      r0 = rd_cnt; w0 = wr_cnt;
      issue(LD, 8'h05, 0, 0, rd, cyc);
      chk("R2 miss data", rd, 32'hA1);
      chk("R1 first load fetched", rd_cnt - r0, 1);
      issue(LD, 8'h05, 0, 0, rd, cyc);
      chk("R2 hit data", rd, 32'hA1);
      chk("R2 hit no stall", cyc, 0);
      chk("R2 hit no read", rd_cnt - r0, 1);
      chk("R2 no writes", wr_cnt - w0, 0);
   endtask

   task automatic t_store();
      logic [DW-1:0] rd; int cyc; int w0;
      w0 = wr_cnt;
      issue(ST, 8'h05, 32'hB2, 0, rd, cyc);
      issue(LD, 8'h05, 0, 0, rd, cyc);
      chk("R3 load sees store", rd, 32'hB2);
      chk("R3 no mem write", wr_cnt - w0, 0);
      chk("R3 mem unchanged", mem[8'h05], 32'hA1);
   endtask

   task automatic t_evict();
      logic [DW-1:0] rd; int cyc; int w0;
      poke(8'h15, 32'hC3);
      w0 = wr_cnt;
      issue(LD, 8'h15, 0, 0, rd, cyc);
      chk("R4 refill data", rd, 32'hC3);
      chk("R4 victim written", mem[8'h05], 32'hB2);
      chk("R4 one write", wr_cnt - w0, 1);
   endtask

   task automatic t_release();
      logic [DW-1:0] rd; int cyc; int w0;
      issue(ST, 8'h06, 32'hD4, 0, rd, cyc);
      issue(ST, 8'h07, 32'hE5, 0, rd, cyc);
      issue(ST, 8'h08, 32'hF6, 1, rd, cyc);
      w0 = wr_cnt;
      fork
         issue(RL, 8'h09, 32'h77, 0, rd, cyc);
         begin
            mem_hold = 1'b1;
            repeat (20) @(negedge clk);
            mem_hold = 1'b0;
         end
      join
      chk("R9 stall held through walk", {31'b0, (cyc > 20)}, 32'd1);
      chk("R5 dirty line 6", mem[8'h06], 32'hD4);
      chk("R5 dirty line 7", mem[8'h07], 32'hE5);
      chk("R5 release datum", mem[8'h09], 32'h77);
      chk("R5 write count", wr_cnt - w0, 3);
      chk("R6 private not flushed", mem[8'h08], 32'h0);
      w0 = wr_cnt;
      issue(RL, 8'h0A, 32'h88, 0, rd, cyc);
      chk("R5 dirty bits cleared", wr_cnt - w0, 1);
      chk("R5 second datum", mem[8'h0A], 32'h88);
   endtask

   task automatic t_acquire();
      logic [DW-1:0] rd; int cyc; int w0, r0;
      poke(8'h0B, 32'h11);
      issue(LD, 8'h0B, 0, 0, rd, cyc);
      poke(8'h0B, 32'h22);
      issue(LD, 8'h0B, 0, 0, rd, cyc);
      chk("R7 stale before acquire", rd, 32'h11);
      issue(ST, 8'h0C, 32'h99, 0, rd, cyc);
      w0 = wr_cnt;
      issue(AQ, 8'h0B, 0, 0, rd, cyc);
      chk("R7 acquire reads memory", rd, 32'h22);
      chk("R10 dirty shared written", mem[8'h0C], 32'h99);
      chk("R10 write count", wr_cnt - w0, 1);
      chk("R6 private not written", mem[8'h08], 32'h0);
      poke(8'h0B, 32'h33);
      poke(8'h09, 32'h99);
      issue(LD, 8'h0B, 0, 0, rd, cyc);
      chk("R8 refetch after acquire", rd, 32'h33);
      issue(LD, 8'h09, 0, 0, rd, cyc);
      chk("R8 clean line dropped", rd, 32'h99);
      r0 = rd_cnt;
      issue(LD, 8'h08, 0, 1, rd, cyc);
      chk("R6 private kept", rd, 32'hF6);
      chk("R6 private hit no read", rd_cnt - r0, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load();
      t_store();
      t_evict();
      t_release();
      t_acquire();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule